// File: doc/BRIEF.md
# Dual-button long-press reset controller

This block supervises the system reset of a chip and drives a single active-low reset output. A hard reset is issued only when two active-low push-buttons are held down together for a programmable number of clock cycles, so a brief tap, a stuck single button or contact bounce never resets the system. Software can therefore wire the same buttons to an interrupt for short presses and rely on this block only when a long two-handed press is made. When only one button is fitted, both inputs are tied to it and the block acts as a plain long-press reset.

The same output is also held low by two supply conditions. The first is a power-on indication, which also serves as the block's synchronous reset. The second is an undervoltage flag from an external comparator. When either condition goes away, the output stays low for one more programmed pulse length. After any timing interval ends, a fixed lockout of `REARM` cycles must pass before a new press can start counting. The button pins pass through a two-stage synchronizer. The setup and pulse counts are captured when an interval starts.

Top module: `dual_press_reset`

## Requirements
- R1: While `pwr_rst` is high, `rst_n_o` is low. When `pwr_rst` is first sampled low at rising edge N (with `uv_i` low), `rst_n_o` goes high after edge N+P, where P is `pulse_len_i` and a value of 0 counts as 1.
- R2: Let E be the first rising edge at which both button pins are sampled low while the block is armed. If both pins stay low through edge E+S (S+1 edges, S = `setup_len_i` ≥ 1), `rst_n_o` falls after edge E+S+2. The two extra edges are the synchronizer.
- R3: No pulse is issued in three cases: a joint press that lasts S edges or fewer, a press of only one button of any length, or a release before expiry. A release before expiry discards the partial count, and a later press times from zero.
- R4: A button-initiated pulse keeps `rst_n_o` low for exactly P cycles. S and P are captured when the setup count starts, so later changes on `setup_len_i` or `pulse_len_i` do not affect that interval.
- R5: When `uv_i` is sampled high at edge N, `rst_n_o` is low after edge N and stays low while `uv_i` stays high. When `uv_i` is first sampled low at edge M, `rst_n_o` rises after edge M+P.
- R6: Holding both buttons continuously gives exactly one pulse. A new setup count can start only after both pins have been seen high together.
- R7: With the two button inputs tied together, a single press lasting S+1 edges or more gives one pulse with the timing of R2 and R4. A press of S edges or fewer gives none.
- R8: If `uv_i` rises during a button-initiated pulse, `rst_n_o` stays low. The pulse then ends P cycles after `uv_i` is first sampled low, as in R5.
- R9: An interval ends when a pulse ends or a setup count is abandoned at edge A. No new setup count starts before edge A+REARM+1. If both buttons are already held at that point, counting starts there, so `rst_n_o` falls after edge A+REARM+1+S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst | input | 1 | Power-on indication and synchronous active-high reset |
| btn_a_n | input | 1 | First push-button, active-low, asynchronous |
| btn_b_n | input | 1 | Second push-button, active-low, asynchronous |
| uv_i | input | 1 | Undervoltage flag from an external comparator, active-high |
| setup_len_i | input | CW | Setup delay in cycles (S) |
| pulse_len_i | input | CW | Reset pulse length in cycles (P) |
| rst_n_o | output | 1 | System reset, active-low |

## Verification
Some properties are checked on every cycle. A pulse may start only after both synchronized buttons were seen low, and only while the lockout counter is empty. No new pulse may start while a held press is waiting for release. An undervoltage sample always drives the output low on the next cycle. The output never rises straight after an undervoltage sample, and the stretch counter steps down by one each cycle. The exact cycle numbers of each fall and rise are shown only by the bench scenarios. These include the synchronizer latency, the exact S+1 boundary against an S-edge press, a single-button hold, tied inputs, changes to the counts during a run, undervoltage in the middle of a pulse, and a press that arrives during the lockout.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int unsigned DPR_CNT_W = 16;
    localparam int unsigned DPR_REARM = 8;

    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,
        TM_COUNT = 2'd1,
        TM_WAIT  = 2'd2
    } tm_state_e;

    typedef enum logic [1:0] {
        PC_HOLD    = 2'd0,
        PC_STRETCH = 2'd1,
        PC_RUN     = 2'd2
    } pc_state_e;

    typedef struct packed {
        logic both_low;
        logic both_high;
    } btn_view_t;

    function automatic btn_view_t decode_buttons(input logic [1:0] pins_n);
        btn_view_t v;
        v.both_low  = (pins_n == 2'b00);
        v.both_high = (pins_n == 2'b11);
        return v;
    endfunction

endpackage

// File: rtl/dpr_sync.sv
module dpr_sync #(
    parameter int unsigned W    = 2,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] pipe;
        always_ff @(posedge clk) begin
            if (srst) begin
                pipe <= {2{INIT[i]}};
            end else begin
                pipe <= {pipe[0], d[i]};
            end
        end
        assign q[i] = pipe[1];
    end

endmodule

// File: rtl/dpr_hold_timer.sv
module dpr_hold_timer
    import dpr_pkg::*;
#(
    parameter int unsigned CW = DPR_CNT_W
) (
    input  logic          clk,
    input  logic          srst,
    input  btn_view_t     view,
    input  logic          armed_i,
    input  logic [CW-1:0] setup_i,
    input  logic [CW-1:0] plen_i,
    output logic [CW-1:0] plen_o,
    output logic          fire_o,
    output logic          abort_o
);

    tm_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim_q, lim_d;
    logic [CW-1:0] len_q, len_d;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        len_d   = len_q;
        fire_o  = 1'b0;
        abort_o = 1'b0;
        case (st_q)
            TM_IDLE: begin
                if (view.both_low && armed_i) begin
                    st_d  = TM_COUNT;
                    cnt_d = CW'(1);
                    lim_d = setup_i;
                    len_d = plen_i;
                end
            end
            TM_COUNT: begin
                if (!armed_i) begin
                    st_d = TM_WAIT;
                end else if (!view.both_low) begin
                    st_d    = TM_IDLE;
                    abort_o = 1'b1;
                end else if (cnt_q >= lim_q) begin
                    fire_o = 1'b1;
                    st_d   = TM_WAIT;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            TM_WAIT: begin
                if (view.both_high) begin
                    st_d = TM_IDLE;
                end
            end
            default: st_d = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q  <= TM_IDLE;
            cnt_q <= '0;
            lim_q <= '0;
            len_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lim_q <= lim_d;
            len_q <= len_d;
        end
    end

    assign plen_o = len_q;

    // R2: a pulse request is preceded by both buttons seen low
    p_fire_after_hold_r2: assert property (@(posedge clk) disable iff (srst)
        fire_o |-> $past(view.both_low));

    // R6: while a held press awaits release, no further request
    p_wait_release_r6: assert property (@(posedge clk) disable iff (srst)
        (st_q == TM_WAIT && !view.both_high) |=> !fire_o);

endmodule

// File: rtl/dpr_pulse_ctl.sv
module dpr_pulse_ctl
    import dpr_pkg::*;
#(
    parameter int unsigned CW    = DPR_CNT_W,
    parameter int unsigned REARM = DPR_REARM
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          uv_i,
    input  logic          fire_i,
    input  logic          abort_i,
    input  logic [CW-1:0] btn_len_i,
    input  logic [CW-1:0] live_len_i,
    output logic          armed_o,
    output logic          rst_n_o
);

    localparam int unsigned LW = (REARM < 1) ? 1 : $clog2(REARM + 1);

    pc_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] lock_q, lock_d;

    function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
        return (v == '0) ? CW'(1) : v;
    endfunction

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        lock_d = lock_q;
        case (st_q)
            PC_HOLD: begin
                if (!uv_i) begin
                    st_d  = PC_STRETCH;
                    cnt_d = at_least_one(live_len_i);
                end
            end
            PC_STRETCH: begin
                if (uv_i) begin
                    st_d = PC_HOLD;
                end else if (cnt_q <= CW'(1)) begin
                    st_d   = PC_RUN;
                    lock_d = LW'(REARM);
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            PC_RUN: begin
                if (uv_i) begin
                    st_d = PC_HOLD;
                end else if (fire_i) begin
                    st_d  = PC_STRETCH;
                    cnt_d = at_least_one(btn_len_i);
                end else if (abort_i) begin
                    lock_d = LW'(REARM);
                end else if (lock_q != '0) begin
                    lock_d = lock_q - LW'(1);
                end
            end
            default: st_d = PC_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q   <= PC_HOLD;
            cnt_q  <= '0;
            lock_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            lock_q <= lock_d;
        end
    end

    assign armed_o = (st_q == PC_RUN) && (lock_q == '0) && !uv_i;
    assign rst_n_o = (st_q == PC_RUN);

    // R5: an undervoltage sample forces the output low next cycle
    p_uv_low_r5: assert property (@(posedge clk) disable iff (srst)
        uv_i |=> !rst_n_o);

    // R5: release never follows a cycle that sampled undervoltage
    p_rise_clean_r5: assert property (@(posedge clk) disable iff (srst)
        $rose(rst_n_o) |-> !$past(uv_i));

    // R4: the stretch count steps down by exactly one
    p_stretch_step_r4: assert property (@(posedge clk) disable iff (srst)
        (st_q == PC_STRETCH && !uv_i && cnt_q > CW'(1))
        |=> (st_q == PC_STRETCH && cnt_q == $past(cnt_q) - CW'(1)));

    // R9: a pulse request only ever arrives with the lockout empty
    p_start_armed_r9: assert property (@(posedge clk) disable iff (srst)
        fire_i |-> (lock_q == '0 && st_q == PC_RUN));

endmodule

// File: rtl/dual_press_reset.sv
module dual_press_reset
    import dpr_pkg::*;
#(
    parameter int unsigned CW    = DPR_CNT_W,
    parameter int unsigned REARM = DPR_REARM
) (
    input  logic          clk,
    input  logic          pwr_rst,
    input  logic          btn_a_n,
    input  logic          btn_b_n,
    input  logic          uv_i,
    input  logic [CW-1:0] setup_len_i,
    input  logic [CW-1:0] pulse_len_i,
    output logic          rst_n_o
);

    logic [1:0]    pins_s;
    btn_view_t     view;
    logic          armed;
    logic          fire;
    logic          abort;
    logic [CW-1:0] btn_len;

    dpr_sync #(
        .W   (2),
        .INIT(2'b11)
    ) u_sync (
        .clk (clk),
        .srst(pwr_rst),
        .d   ({btn_b_n, btn_a_n}),
        .q   (pins_s)
    );

    assign view = decode_buttons(pins_s);

    dpr_hold_timer #(
        .CW(CW)
    ) u_timer (
        .clk    (clk),
        .srst   (pwr_rst),
        .view   (view),
        .armed_i(armed),
        .setup_i(setup_len_i),
        .plen_i (pulse_len_i),
        .plen_o (btn_len),
        .fire_o (fire),
        .abort_o(abort)
    );

    dpr_pulse_ctl #(
        .CW   (CW),
        .REARM(REARM)
    ) u_pulse (
        .clk       (clk),
        .srst      (pwr_rst),
        .uv_i      (uv_i),
        .fire_i    (fire),
        .abort_i   (abort),
        .btn_len_i (btn_len),
        .live_len_i(pulse_len_i),
        .armed_o   (armed),
        .rst_n_o   (rst_n_o)
    );

endmodule

// File: tb/dual_press_reset_tb.sv
module dual_press_reset_tb;

    localparam int CW    = 16;
    localparam int REARM = 8;
    localparam int S     = 6;
    localparam int P     = 10;

    logic          clk = 1'b0;
    logic          pwr_rst = 1'b1;
    logic          btn_a_n = 1'b1;
    logic          btn_b_n = 1'b1;
    logic          uv_i = 1'b0;
    logic [CW-1:0] setup_len_i = CW'(S);
    logic [CW-1:0] pulse_len_i = CW'(P);
    logic          rst_n_o;

    dual_press_reset #(.CW(CW), .REARM(REARM)) u_dut (
        .clk        (clk),
        .pwr_rst    (pwr_rst),
        .btn_a_n    (btn_a_n),
        .btn_b_n    (btn_b_n),
        .uv_i       (uv_i),
        .setup_len_i(setup_len_i),
        .pulse_len_i(pulse_len_i),
        .rst_n_o    (rst_n_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    fall;
        int    rise;
        string tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   n_rise = 0;
    bit   done   = 1'b0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic expect_pulse(int fall, int rise, string tag);
        exp_t e;
        e.fall = fall;
        e.rise = rise;
        e.tag  = tag;
        expq.push_back(e);
    endtask

    // called at a falling edge; buttons low for 'edges' rising edges
    task automatic press(int edges);
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        repeat (edges) @(negedge clk);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor: pops the expected item on each release of the reset
    initial begin
        bit prev;
        int fall_c;
        prev   = 1'b0;
        fall_c = -1;
        forever begin
            @(negedge clk);
            if (rst_n_o && !prev) begin
                n_rise++;
                if (expq.size() == 0) begin
                    check(1'b0, "R3", "unexpected pulse released at cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(fall_c == e.fall, e.tag, "fall cycle", fall_c, e.fall);
                    check(cyc == e.rise, e.tag, "rise cycle", cyc, e.rise);
                end
            end
            if (!rst_n_o && prev) fall_c = cyc;
            prev = rst_n_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        int n;
        int e1;
        int f;
        int m;
        int r0;

        // R1: power-on hold and stretch
        repeat (4) @(negedge clk);
        check(rst_n_o == 1'b0, "R1", "output during power-on", rst_n_o, 0);
        n = cyc;
        expect_pulse(-1, n + 1 + P, "R1");
        pwr_rst = 1'b0;
        wait_to(n + P);
        check(rst_n_o == 1'b0, "R1", "output one cycle before release", rst_n_o, 0);
        repeat (20) @(negedge clk);

        // R3: joint press of exactly S edges is ignored
        r0 = n_rise;
        press(S);
        repeat (40) @(negedge clk);
        check(n_rise == r0 && rst_n_o, "R3", "pulses after S-edge press", n_rise - r0, 0);

        // R3: one button held for a long time is ignored
        btn_a_n = 1'b0;
        repeat (100) @(negedge clk);
        btn_a_n = 1'b1;
        repeat (10) @(negedge clk);
        check(n_rise == r0 && rst_n_o, "R3", "pulses after single-button hold", n_rise - r0, 0);

        // R2 R4: exact S+1 edge press, counts changed mid-run
        e1 = cyc + 1;
        f  = e1 + 2 + S;
        expect_pulse(f, f + P, "R2 R4");
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        wait_to(e1 + 3);
        setup_len_i = CW'(200);
        pulse_len_i = CW'(3);
        wait_to(e1 + S);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        wait_to(f + P - 1);
        check(rst_n_o == 1'b0, "R4", "output on last pulse cycle", rst_n_o, 0);
        wait_to(f + P + 2);
        setup_len_i = CW'(S);
        pulse_len_i = CW'(P);
        repeat (20) @(negedge clk);

        // R2: staggered buttons, timing from the second one
        btn_a_n = 1'b0;
        repeat (5) @(negedge clk);
        e1 = cyc + 1;
        f  = e1 + 2 + S;
        expect_pulse(f, f + P, "R2");
        btn_b_n = 1'b0;
        wait_to(e1 + S);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        repeat (40) @(negedge clk);

        // R6: a continuous hold gives exactly one pulse
        r0 = n_rise;
        e1 = cyc + 1;
        f  = e1 + 2 + S;
        expect_pulse(f, f + P, "R6");
        press(80);
        repeat (30) @(negedge clk);
        check(n_rise == r0 + 1, "R6", "pulses from one long hold", n_rise - r0, 1);

        // R7: tied inputs with other counts
        setup_len_i = CW'(3);
        pulse_len_i = CW'(5);
        repeat (2) @(negedge clk);
        r0 = n_rise;
        press(3);
        repeat (30) @(negedge clk);
        check(n_rise == r0, "R7", "pulses after short tied press", n_rise - r0, 0);
        e1 = cyc + 1;
        expect_pulse(e1 + 2 + 3, e1 + 2 + 3 + 5, "R7");
        press(4);
        repeat (30) @(negedge clk);
        setup_len_i = CW'(S);
        pulse_len_i = CW'(P);
        repeat (2) @(negedge clk);

        // R5: undervoltage hold and stretch
        n = cyc;
        m = n + 7;
        expect_pulse(n + 1, m + 1 + P, "R5");
        uv_i = 1'b1;
        wait_to(m);
        check(rst_n_o == 1'b0, "R5", "output while undervoltage", rst_n_o, 0);
        uv_i = 1'b0;
        wait_to(m + P);
        check(rst_n_o == 1'b0, "R5", "output late in stretch", rst_n_o, 0);
        repeat (30) @(negedge clk);

        // R8: undervoltage during a button pulse restarts the stretch
        e1 = cyc + 1;
        f  = e1 + 2 + S;
        m  = f + 8;
        expect_pulse(f, m + 1 + P, "R8");
        press(S + 1);
        wait_to(f + 3);
        uv_i = 1'b1;
        wait_to(m);
        uv_i = 1'b0;
        repeat (P + 30) @(negedge clk);

        // R9: re-press during the lockout after an abandoned count
        e1 = cyc + 1;
        f  = e1 + S + 2 + REARM + 1 + S;
        expect_pulse(f, f + P, "R9");
        press(S);
        @(negedge clk);
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        wait_to(e1 + 2 * S + 4);
        check(rst_n_o == 1'b1, "R9", "output while lockout delays start", rst_n_o, 1);
        wait_to(f + 5);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        repeat (40) @(negedge clk);

        check(expq.size() == 0, "R2", "expected pulses never seen", expq.size(), 0);
        report();
    end

endmodule